// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Status Flags

This block is a clocked, full-duplex serial channel that moves 8-bit frames least significant bit first. The block is the clock master. It drives the serial clock from a fixed divider of the system clock, presents each transmit bit on the falling edge and samples the receive line on the rising edge. A host writes a byte into the transmit data register. At a frame boundary that byte moves into a shift register. Each byte that arrives is moved from the receive shift register into the receive data register.

Three status flags report the channel state: transmit-empty, receive-full and overrun. A rising transmit-empty or receive-full flag produces a one-cycle interrupt request. A DMA engine can answer those requests through two strobes: a DMA write of the transmit data clears transmit-empty, and a DMA read of the receive data clears receive-full. A receive overrun freezes the whole channel until software clears the overrun flag. Software clears any flag in two steps: it reads the flag as 1, then writes 0 to that bit.

Top module: `sync_serial_port`

## Requirements
- R1: With both enables set, every frame shifts the transmit byte out on `txd` LSB first and shifts the `rxd` byte in LSB first. `txd` changes when `sck` falls and `rxd` is sampled when `sck` rises.
- R2: The register at address 0 holds the transmit enable in bit 0 and the receive enable in bit 1. One write sets or clears both bits, and the register reads back what was written.
- R3: `tx_irq` and `rx_irq` each pulse for exactly one cycle when transmit-empty (status bit 0) or receive-full (status bit 1) goes from 0 to 1.
- R4: While overrun (status bit 2) is 1, `sck` stays high and no frame starts, even if transmit data is pending. Frames resume after software clears the flag.
- R5: A frame that completes while receive-full is 1 sets overrun. The receive data register (address 3) keeps its old byte and the new byte is lost.
- R6: If the next transmit byte is written and its flag cleared before the current frame ends, the next frame begins with no idle gap: its first falling edge comes one bit period after the previous frame's last falling edge.
- R7: A `dma_tx_wr` strobe loads `dma_wdata` as transmit data and clears transmit-empty. A `dma_rx_rd` strobe clears receive-full, and `dma_rdata` carries the received byte.
- R8: A status flag (address 1) is cleared only when 0 is written to its bit after the flag was read as 1. Writing 1, or writing 0 without a prior read of 1, leaves the flag unchanged.
- R9: Transmit data (address 2) moves into the shift register only while transmit-empty is 0, and the move sets transmit-empty to 1. With transmit enabled and nothing pending, `sck` stays high.
- R10: After reset the control register reads 0, status reads 0x01, and `sck` and `txd` are high.
- R11: With only the receive enable set, frames run back to back without transmit data, and `txd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (arms flag clearing on a status read) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the selected register |
| dma_tx_wr | input | 1 | DMA write of transmit data |
| dma_wdata | input | 8 | DMA transmit byte |
| dma_rx_rd | input | 1 | DMA read of receive data |
| dma_rdata | output | 8 | Receive data register seen by the DMA |
| tx_irq | output | 1 | Transmit-empty rising pulse |
| rx_irq | output | 1 | Receive-full rising pulse |
| sck | output | 1 | Serial clock, idle high |
| txd | output | 1 | Serial transmit data, idle high |
| rxd | input | 1 | Serial receive data |

## Verification
On every cycle the assertions check that `sck` is high while overrun holds, that the interrupt pulses occur only on a real rising edge of their flag, and that the receive register does not change in the cycle overrun is raised. They also check that a DMA strobe clears its flag in the next cycle and that writing 1 to the receive-full bit does not clear it. Only the bench's serial scenarios can show the following: bit order and edge placement on the wires, the absence of a gap between back-to-back frames, the resumption of frames after overrun is cleared, and continuous operation in receive-only mode.

// File: rtl/ssp_pkg.sv
// Shared constants and types for the synchronous serial port.
// Assumes 8-bit frames; the status bit positions are software visible.
package ssp_pkg;
    localparam int unsigned FRAME_BITS = 8;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] word_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_sel_e;

    localparam int unsigned ST_TXE = 0;
    localparam int unsigned ST_RXF = 1;
    localparam int unsigned ST_OVR = 2;
    localparam int unsigned ST_W   = 3;
endpackage

// File: rtl/ssp_bitclk.sv
// Serial clock sequencer: produces an idle-high clock for one frame
// at a time, with one-cycle strobes at each falling and rising edge.
// Assumes the start request is held by the caller until accepted, and
// that it is only looked at while idle or at the end of a frame.
module ssp_bitclk
    import ssp_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic go,
    output logic sck,
    output logic fall_stb,
    output logic rise_stb,
    output logic last_rise,
    output logic frame_end
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] HC_LAST = CNT_W'(HALF_DIV - 1);
    localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(FRAME_BITS - 1);

    logic             busy_q;
    logic             sck_q;
    logic [CNT_W-1:0] hc_q;
    logic [IDX_W-1:0] bit_q;
    logic             hc_end;
    logic             at_last;

    // Edge and boundary strobes derived from the phase counters.
    always_comb begin
        hc_end    = busy_q && (hc_q == HC_LAST);
        at_last   = (bit_q == BIT_LAST);
        frame_end = hc_end && sck_q && at_last;
        go        = start && (!busy_q || frame_end);
        fall_stb  = go || (hc_end && sck_q && !at_last);
        rise_stb  = hc_end && !sck_q;
        last_rise = rise_stb && at_last;
    end

    // Phase counter, bit counter and serial clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b1;
            hc_q   <= '0;
            bit_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                sck_q  <= 1'b0;
                hc_q   <= '0;
                bit_q  <= '0;
            end
        end else if (!hc_end) begin
            hc_q <= hc_q + 1'b1;
        end else begin
            hc_q <= '0;
            if (!sck_q) begin
                sck_q <= 1'b1;
            end else if (at_last) begin
                if (start) begin
                    sck_q <= 1'b0;
                    bit_q <= '0;
                end else begin
                    busy_q <= 1'b0;
                end
            end else begin
                sck_q <= 1'b0;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign sck = sck_q;
endmodule

// File: rtl/ssp_tx.sv
// Transmit shifter: presents a loaded byte LSB first, one bit per
// shift strobe, and returns the line high when the channel goes idle.
// Assumes load and shift are never asserted together.
module ssp_tx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t load_word,
    input  logic  shift,
    input  logic  idle,
    output logic  txd
);
    word_t sreg_q;
    logic  txd_q;

    // Load, shift or park the output line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '1;
            txd_q  <= 1'b1;
        end else if (load) begin
            txd_q  <= load_word[0];
            sreg_q <= {1'b1, load_word[FRAME_BITS-1:1]};
        end else if (shift) begin
            txd_q  <= sreg_q[0];
            sreg_q <= {1'b1, sreg_q[FRAME_BITS-1:1]};
        end else if (idle) begin
            txd_q  <= 1'b1;
        end
    end

    assign txd = txd_q;
endmodule

// File: rtl/ssp_rx.sv
// Receive shifter: samples the line on each strobe, LSB first. The
// output shows the completed byte including the bit being sampled, so
// the caller can capture it on the final sampling strobe.
module ssp_rx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample,
    input  logic  rxd,
    output word_t next_word
);
    word_t sreg_q;

    // Shift the sampled bit in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (sample) begin
            sreg_q <= {rxd, sreg_q[FRAME_BITS-1:1]};
        end
    end

    assign next_word = {rxd, sreg_q[FRAME_BITS-1:1]};
endmodule

// File: rtl/sync_serial_port.sv
// Synchronous full-duplex serial port with host registers, status
// flags, interrupt pulses and DMA strobes. Assumes host and DMA do not
// address the same data register in the same cycle.
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       dma_tx_wr,
    input  logic [7:0] dma_wdata,
    input  logic       dma_rx_rd,
    output logic [7:0] dma_rdata,
    output logic       tx_irq,
    output logic       rx_irq,
    output logic       sck,
    output logic       txd,
    input  logic       rxd
);
    logic            tx_en_q, rx_en_q, rx_act_q;
    word_t           tdr_q, rdr_q;
    logic            txe_q, rxf_q, ovr_q, txe_d_q, rxf_d_q;
    logic [ST_W-1:0] armed_q, flags, sw_clr;
    logic            wr_ctrl, wr_stat, wr_tdr, rd_stat;
    logic            want, go, fall_stb, rise_stb, last_rise, frame_end;
    logic            capture;
    word_t           rx_word, load_word;

    // Host access decode and two-step flag clear.
    always_comb begin
        wr_ctrl = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
        wr_stat = bus_wr && (reg_sel_e'(bus_addr) == REG_STAT);
        wr_tdr  = bus_wr && (reg_sel_e'(bus_addr) == REG_TXD);
        rd_stat = bus_rd && (reg_sel_e'(bus_addr) == REG_STAT);
        flags   = {ovr_q, rxf_q, txe_q};
        sw_clr  = {ST_W{wr_stat}} & armed_q & ~bus_wdata[ST_W-1:0];
    end

    // Frame request: no overrun, some enable, and data if transmitting.
    always_comb begin
        want      = !ovr_q && (tx_en_q || rx_en_q) && (!tx_en_q || !txe_q);
        load_word = tx_en_q ? tdr_q : '1;
        capture   = rx_act_q && last_rise;
    end

    ssp_bitclk #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .start(want), .go(go), .sck(sck),
        .fall_stb(fall_stb), .rise_stb(rise_stb), .last_rise(last_rise),
        .frame_end(frame_end)
    );

    ssp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .load(go), .load_word(load_word),
        .shift(fall_stb && !go), .idle(frame_end && !go), .txd(txd)
    );

    ssp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sample(rise_stb), .rxd(rxd),
        .next_word(rx_word)
    );

    // Control and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            rx_act_q <= 1'b0;
            tdr_q    <= '0;
            rdr_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                tx_en_q <= bus_wdata[0];
                rx_en_q <= bus_wdata[1];
            end
            if (dma_tx_wr)   tdr_q <= dma_wdata;
            else if (wr_tdr) tdr_q <= bus_wdata;
            if (go)          rx_act_q <= rx_en_q;
            if (capture && !rxf_q) rdr_q <= rx_word;
        end
    end

    // Status flags, their read arming, and edge history for interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe_q   <= 1'b1;
            rxf_q   <= 1'b0;
            ovr_q   <= 1'b0;
            armed_q <= '0;
            txe_d_q <= 1'b1;
            rxf_d_q <= 1'b0;
        end else begin
            if (dma_tx_wr || sw_clr[ST_TXE]) txe_q <= 1'b0;
            else if (go && tx_en_q)          txe_q <= 1'b1;
            if (capture && !rxf_q)               rxf_q <= 1'b1;
            else if (dma_rx_rd || sw_clr[ST_RXF]) rxf_q <= 1'b0;
            if (capture && rxf_q)    ovr_q <= 1'b1;
            else if (sw_clr[ST_OVR]) ovr_q <= 1'b0;
            armed_q <= flags & ~sw_clr & (armed_q | {ST_W{rd_stat}});
            txe_d_q <= txe_q;
            rxf_d_q <= rxf_q;
        end
    end

    // Host read multiplexer.
    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_CTRL: bus_rdata = {6'b0, rx_en_q, tx_en_q};
            REG_STAT: bus_rdata = {5'b0, flags};
            REG_TXD:  bus_rdata = tdr_q;
            default:  bus_rdata = rdr_q;
        endcase
    end

    assign tx_irq    = txe_q && !txe_d_q;
    assign rx_irq    = rxf_q && !rxf_d_q;
    assign dma_rdata = rdr_q;
endmodule

// File: rtl/ssp_checker.sv
// Cycle-level property checker for sync_serial_port, attached by bind.
module ssp_checker
    import ssp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       tx_irq,
    input logic       rx_irq,
    input logic       txe,
    input logic       rxf,
    input logic       ovr,
    input word_t      rdr,
    input logic       dma_tx_wr,
    input logic       dma_rx_rd,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata
);
    p_overrun_holds_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> sck);

    p_tx_irq_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (txe && !$past(txe)));

    p_rx_irq_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rxf && !$past(rxf)));

    p_rdr_kept_on_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rdr));

    p_dma_tx_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_wr |=> !txe);

    p_dma_rx_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_rd && rxf) |=> !rxf);

    p_write_one_keeps_rxf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[ST_RXF] && rxf && !dma_rx_rd) |=> rxf);
endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .txe(txe_q), .rxf(rxf_q), .ovr(ovr_q), .rdr(rdr_q),
    .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_sync_serial_port.sv
// Self-checking bench: a vector table of full-duplex frames, then
// directed tests for flag clearing, back-to-back, overrun, DMA and
// receive-only operation. A serial slave model drives rxd.
module tb_sync_serial_port;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 2;
    localparam int BIT_NS = 2 * HALF * 8;
    localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h0180, 16'hFF00, 16'h5AC3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       dma_tx_wr = 1'b0, dma_rx_rd = 1'b0;
    logic [7:0] dma_wdata = '0, dma_rdata;
    logic       tx_irq, rx_irq, sck, txd;
    logic       rxd;

    int checks = 0, fails = 0;
    int txi, rxi, fall_cnt, rise_cnt;
    logic [7:0] slave_q [8];
    logic [7:0] cap_q [8];
    logic [7:0] cap;
    realtime    fall_t [32];
    logic [7:0] d;

    sync_serial_port #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_tx_wr(dma_tx_wr), .dma_wdata(dma_wdata), .dma_rx_rd(dma_rx_rd),
        .dma_rdata(dma_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .sck(sck), .txd(txd), .rxd(rxd)
    );

    always #4 clk = ~clk;

    // Slave model: drives its byte LSB first on each falling edge.
    always @(negedge sck or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt = 0;
            rxd = 1'b1;
        end else begin
            rxd = slave_q[(fall_cnt / 8) % 8][fall_cnt % 8];
            if (fall_cnt < 32) fall_t[fall_cnt] = $realtime;
            fall_cnt++;
        end
    end

    // Slave model: samples txd on each rising edge.
    always @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt = 0;
            cap = '0;
        end else begin
            cap = {txd, cap[7:1]};
            rise_cnt++;
            if (rise_cnt % 8 == 0) cap_q[(rise_cnt / 8 - 1) % 8] = cap;
        end
    end

    // Interrupt pulse counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            txi <= 0;
            rxi <= 0;
        end else begin
            if (tx_irq) txi <= txi + 1;
            if (rx_irq) rxi <= rxi + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_flag(input int bitpos);
        logic [7:0] t;
        bus_read(2'd1, t);
        bus_write(2'd1, ~(8'h01 << bitpos));
    endtask

    task automatic wait_rx(input int target, input string req);
        int n = 0;
        while (rxi < target && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({req, " rx_irq count"}, rxi, target);
    endtask

    task automatic wait_tx(input int target, input string req);
        int n = 0;
        while (txi < target && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({req, " tx_irq count"}, txi, target);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck !== 1'b1) lows++;
        end
        check({req, " sck held high"}, lows, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; dma_tx_wr = 1'b0; dma_rx_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) slave_q[i] = 8'h00;
        do_reset();

        // R10: reset state
        bus_read(2'd0, d); check("R10 ctrl", d, 8'h00);
        bus_read(2'd1, d); check("R10 status", d, 8'h01);
        check("R10 sck", sck, 1); check("R10 txd", txd, 1);

        // R2: both enables in one write
        bus_write(2'd0, 8'h03);
        bus_read(2'd0, d); check("R2 ctrl readback", d, 8'h03);

        // R1/R3/R9: vector table of full-duplex frames
        for (int k = 0; k < 4; k++) begin
            slave_q[k] = VEC[k][7:0];
            bus_write(2'd2, VEC[k][15:8]);
            clear_flag(0);
            wait_rx(k + 1, "R1");
            check("R1 txd byte", cap_q[k], VEC[k][15:8]);
            bus_read(2'd3, d); check("R1 rxd byte", d, VEC[k][7:0]);
            check("R3 tx pulses", txi, k + 1);
            bus_read(2'd1, d); check("R9 status after frame", d, 8'h03);
            expect_quiet(20, "R9");
            clear_flag(1);
        end
        bus_read(2'd1, d); check("R9 status idle", d, 8'h01);

        // R8: two-step clear of receive-full
        slave_q[4] = 8'h66;
        bus_write(2'd2, 8'h99);
        clear_flag(0);
        wait_rx(5, "R8");
        bus_write(2'd1, 8'hFD);
        bus_read(2'd1, d); check("R8 write0 without read", d, 8'h03);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, d); check("R8 write1 no effect", d, 8'h03);
        bus_write(2'd1, 8'hFD);
        bus_read(2'd1, d); check("R8 read then write0", d, 8'h01);
        bus_read(2'd3, d); check("R8 data", d, 8'h66);

        // R6: back-to-back frames without gap
        do_reset();
        slave_q[0] = 8'h11; slave_q[1] = 8'h22;
        bus_write(2'd0, 8'h03);
        bus_write(2'd2, 8'hC1);
        clear_flag(0);
        wait_tx(1, "R6");
        bus_write(2'd2, 8'hC2);
        clear_flag(0);
        wait_rx(1, "R6");
        bus_read(2'd3, d); check("R6 first byte", d, 8'h11);
        clear_flag(1);
        wait_rx(2, "R6");
        check("R6 boundary spacing ns", int'(fall_t[8] - fall_t[7]), BIT_NS);
        bus_read(2'd3, d); check("R6 second byte", d, 8'h22);
        bus_read(2'd1, d); check("R6 no overrun", d, 8'h03);
        check("R6 second tx byte", cap_q[1], 8'hC2);

        // R5/R4: overrun keeps old byte and freezes the channel
        do_reset();
        slave_q[0] = 8'h31; slave_q[1] = 8'h32; slave_q[2] = 8'h33;
        bus_write(2'd0, 8'h03);
        bus_write(2'd2, 8'h41);
        clear_flag(0);
        wait_tx(1, "R5");
        bus_write(2'd2, 8'h42);
        clear_flag(0);
        repeat (80) @(negedge clk);
        bus_read(2'd1, d); check("R5 overrun status", d, 8'h07);
        bus_read(2'd3, d); check("R5 old byte kept", d, 8'h31);
        bus_write(2'd2, 8'h43);
        clear_flag(0);
        expect_quiet(64, "R4");
        bus_read(2'd1, d); check("R4 pending while frozen", d, 8'h06);
        clear_flag(1);
        clear_flag(2);
        wait_rx(2, "R4");
        bus_read(2'd3, d); check("R4 resumed byte", d, 8'h33);
        check("R4 resumed tx byte", cap_q[2], 8'h43);

        // R7: DMA strobes clear flags
        do_reset();
        slave_q[0] = 8'h5E;
        bus_write(2'd0, 8'h03);
        @(negedge clk); dma_wdata = 8'h7E; dma_tx_wr = 1'b1;
        @(negedge clk); dma_tx_wr = 1'b0;
        wait_rx(1, "R7");
        check("R7 dma rdata", dma_rdata, 8'h5E);
        check("R7 tx byte", cap_q[0], 8'h7E);
        @(negedge clk); dma_rx_rd = 1'b1;
        @(negedge clk); dma_rx_rd = 1'b0;
        bus_read(2'd1, d); check("R7 status", d, 8'h01);

        // R11: receive-only continuous frames, txd high
        do_reset();
        slave_q[0] = 8'hA1; slave_q[1] = 8'hB2;
        bus_write(2'd0, 8'h02);
        wait_rx(1, "R11");
        bus_read(2'd3, d); check("R11 first byte", d, 8'hA1);
        clear_flag(1);
        wait_rx(2, "R11");
        bus_read(2'd3, d); check("R11 second byte", d, 8'hB2);
        check("R11 txd idle", cap_q[0], 8'hFF);
        bus_write(2'd0, 8'h00);

        summary();
        $finish;
    end
endmodule